// File: doc/BRIEF.md
# Periodic Status Snapshot Register with Host-Priority Arbitration

This block holds a host-readable status word that is copied from an internal status vector on a fixed periodic slot. A prescaler divides the input clock into a peripheral-clock enable by a selectable power of two. A slot timer counts three of those enables and then raises an update strobe. Each strobe copies the internal vector into the register.

The host reads through a one-cycle read strobe, and the captured word appears on a registered data bus. When a read strobe and an update strobe fall in the same cycle, the read proceeds and the update for that slot is discarded. A discarded update is not retried, so the register keeps its old value until the next slot.

A host that polls in step with the update period can therefore starve the register for as long as it keeps polling. A one-cycle debug pulse flags each discarded update. A saturating counter of consecutive discards lets a testbench measure starvation.

Top module: `periodic_status_reg`

## Requirements
- R1: While rst_ni is low, the outputs are as follows: rd_data_o is 0, drop_pulse_o is 0 and drop_run_o is 0. The register itself is 0, and a read after reset with no completed update returns 0.
- R2: The value of div_sel_i sets the peripheral-clock division. A value n in 0..4 divides by 2^n, and the values 5, 6 and 7 divide by 16. A new value is taken only at the end of the current peripheral-clock period, so no period is ever shortened.
- R3: An update slot occurs once every 3 peripheral-clock periods, which is 3*2^n input cycles at setting n. The first slot after reset falls 3 enables after reset release, and the first enable falls in the first cycle.
- R4: In a slot cycle with rd_stb_i low, the register loads status_i as sampled in that cycle.
- R5: In a slot cycle with rd_stb_i high, the read is served and the register keeps its old value. The discarded update is not retried before the next slot.
- R6: drop_pulse_o is high for exactly the one cycle that follows each discarded slot, and is low otherwise.
- R7: drop_run_o increments after each discarded slot and saturates at 255. It returns to 0 after a slot whose update succeeds.
- R8: In the cycle after rd_stb_i is high, rd_data_o shows the register value from the strobe cycle. rd_data_o holds its value when no read is made.
- R9: With rd_stb_i held high continuously, every slot is discarded. The register then never changes, and drop pulses appear exactly 3*2^n cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_sel_i | input | 3 | Peripheral-clock division select |
| status_i | input | STAT_W | Internal status vector to snapshot |
| rd_stb_i | input | 1 | Host read strobe, one cycle per read |
| rd_data_o | output | STAT_W | Register value captured by the last read |
| drop_pulse_o | output | 1 | One-cycle flag for a discarded update |
| drop_run_o | output | 8 | Saturating count of consecutive discarded updates |

## Verification
The assertions assume that every input changes only between clock edges and that reset is released away from an edge. The stimulus drives all inputs on the falling edge, so each input is stable across the rising edge that samples it. The assertions accept any div_sel_i value at any time, because the prescaler latches the setting only at a boundary. The stimulus exploits this by changing the setting in the middle of peripheral periods and by using the out-of-range codes. Reads are random, continuous, or absent, so that discarded slots, successful slots and starvation all occur under every division setting.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned DIV_LOG2_MAX = 4;
  localparam int unsigned DIV_CNT_W    = DIV_LOG2_MAX;
  localparam int unsigned SEL_W        = 3;
  localparam int unsigned RUN_W        = 8;

  // terminal count of the divider for a select code; codes above the max clamp
  function automatic logic [DIV_CNT_W-1:0] div_limit(input logic [SEL_W-1:0] sel);
    if (int'(sel) > int'(DIV_LOG2_MAX)) return '1;
    return DIV_CNT_W'((1 << sel) - 1);
  endfunction
endpackage

// File: rtl/psr_prescaler.sv
module psr_prescaler
  import psr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] div_sel_i,
  output logic             pclk_en_o
);
  logic [DIV_CNT_W-1:0] cnt_q, lim_q;

  assign pclk_en_o = (cnt_q == lim_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (pclk_en_o) begin
      cnt_q <= '0;
      lim_q <= div_limit(div_sel_i);  // select taken only at a boundary
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_lim_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pclk_en_o |=> $stable(lim_q));
  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pclk_en_o |=> cnt_q == '0);
endmodule

// File: rtl/psr_slot_timer.sv
module psr_slot_timer #(
  parameter int unsigned SLOT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pclk_en_i,
  output logic upd_stb_o
);
  localparam int unsigned SLOT_W = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_LEN - 1);

  logic [SLOT_W-1:0] slot_q;

  assign upd_stb_o = pclk_en_i && (slot_q == SLOT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        slot_q <= '0;
    else if (upd_stb_o) slot_q <= '0;
    else if (pclk_en_i) slot_q <= slot_q + 1'b1;
  end

  assert_slot_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_stb_o |=> slot_q == '0);
  assert_slot_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pclk_en_i |=> $stable(slot_q));
endmodule

// File: rtl/psr_collide.sv
module psr_collide
  import psr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_stb_i,
  input  logic             rd_stb_i,
  output logic             upd_win_o,
  output logic             drop_pulse_o,
  output logic [RUN_W-1:0] drop_run_o
);
  logic drop;

  assign drop      = upd_stb_i && rd_stb_i;   // host always wins
  assign upd_win_o = upd_stb_i && !rd_stb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drop_pulse_o <= 1'b0;
      drop_run_o   <= '0;
    end else begin
      drop_pulse_o <= drop;
      if (upd_win_o)                 drop_run_o <= '0;
      else if (drop && !(&drop_run_o)) drop_run_o <= drop_run_o + 1'b1;
    end
  end

  assert_pulse_has_run_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_pulse_o |-> drop_run_o != '0);
  assert_run_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_win_o |=> drop_run_o == '0);
  assert_run_sat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&drop_run_o && !upd_win_o) |=> &drop_run_o);
endmodule

// File: rtl/periodic_status_reg.sv
module periodic_status_reg
  import psr_pkg::*;
#(
  parameter int unsigned STAT_W   = 16,
  parameter int unsigned SLOT_LEN = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  div_sel_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic              rd_stb_i,
  output logic [STAT_W-1:0] rd_data_o,
  output logic              drop_pulse_o,
  output logic [RUN_W-1:0]  drop_run_o
);
  logic pclk_en, upd_stb, upd_win;
  logic [STAT_W-1:0] stat_q;

  psr_prescaler u_prescaler (
    .clk_i, .rst_ni, .div_sel_i, .pclk_en_o(pclk_en)
  );

  psr_slot_timer #(.SLOT_LEN(SLOT_LEN)) u_slot (
    .clk_i, .rst_ni, .pclk_en_i(pclk_en), .upd_stb_o(upd_stb)
  );

  psr_collide u_collide (
    .clk_i, .rst_ni, .upd_stb_i(upd_stb), .rd_stb_i,
    .upd_win_o(upd_win), .drop_pulse_o, .drop_run_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q    <= '0;
      rd_data_o <= '0;
    end else begin
      if (upd_win)  stat_q    <= status_i;
      if (rd_stb_i) rd_data_o <= stat_q;
    end
  end

  assert_update_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_win |=> stat_q == $past(status_i));
  assert_drop_keeps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_stb && rd_stb_i) |=> $stable(stat_q));
  assert_rd_capture_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stb_i |=> rd_data_o == $past(stat_q));
  assert_rd_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_stb_i |=> $stable(rd_data_o));
endmodule

// File: tb/periodic_status_reg_bench.sv
`timescale 1ns/1ps
module periodic_status_reg_bench;
  localparam int STAT_W = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [2:0]        div_sel_i = '0;
  logic [STAT_W-1:0] status_i = '0;
  logic              rd_stb_i = 1'b0;
  logic [STAT_W-1:0] rd_data_o;
  logic              drop_pulse_o;
  logic [7:0]        drop_run_o;

  int n_chk = 0, n_err = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  periodic_status_reg u_periodic_status_reg (
    .clk_i, .rst_ni, .div_sel_i, .status_i, .rd_stb_i,
    .rd_data_o, .drop_pulse_o, .drop_run_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // divider terminal count per R2
  function automatic int lim_of(input int sel);
    return (sel > 4) ? 15 : (1 << sel) - 1;
  endfunction

  // behavioural model built from R2..R8
  int m_cnt, m_lim, m_slot, m_reg, m_rd, m_run;
  bit m_drop;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_lim = 0; m_slot = 0; m_reg = 0; m_rd = 0; m_run = 0; m_drop = 0;
    end else begin
      bit pen, upd;
      pen = (m_cnt == m_lim);
      upd = pen && (m_slot == 2);
      if (pen) begin m_cnt = 0; m_lim = lim_of(int'(div_sel_i)); end
      else m_cnt++;
      if (pen) m_slot = (m_slot == 2) ? 0 : m_slot + 1;
      if (rd_stb_i) m_rd = m_reg;
      m_drop = upd && rd_stb_i;
      if (upd) begin
        if (rd_stb_i) m_run = (m_run < 255) ? m_run + 1 : 255;
        else begin m_reg = int'(status_i); m_run = 0; end
      end
    end
  end

  always @(negedge clk_i) if (rst_ni && cmp_en) begin
    chk(int'(rd_data_o) == m_rd, "R8 rd_data", int'(rd_data_o), m_rd);
    chk(drop_pulse_o == m_drop, "R6 drop_pulse", int'(drop_pulse_o), int'(m_drop));
    chk(int'(drop_run_o) == m_run, "R7 drop_run", int'(drop_run_o), m_run);
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    int held, last_p, cnt;
    cyc(3);
    // R1: reset values
    chk(rd_data_o == '0, "R1 rd_data", int'(rd_data_o), 0);
    chk(drop_pulse_o == 1'b0, "R1 drop_pulse", int'(drop_pulse_o), 0);
    chk(drop_run_o == '0, "R1 drop_run", int'(drop_run_o), 0);
    rst_ni = 1'b1;
    cmp_en = 1'b1;
    // R1: read before first slot (slot at 3rd enable) returns 0
    status_i = 16'hBEEF;
    rd_stb_i = 1'b1; cyc(1); rd_stb_i = 1'b0; cyc(1);
    chk(rd_data_o == '0, "R1 early read", int'(rd_data_o), 0);

    // R2 R3 R4 R5: random sweep over every select code, changed mid-period
    for (int s = 0; s < 8; s++) begin
      div_sel_i = 3'(s);
      for (int k = 0; k < 600; k++) begin
        @(negedge clk_i);
        status_i = 16'($urandom);
        rd_stb_i = (($urandom % 4) == 0);
      end
    end
    rd_stb_i = 1'b0;

    // R4: quiet interval, then read returns the held status
    div_sel_i = 3'd1; status_i = 16'h5A3C;
    cyc(40);
    rd_stb_i = 1'b1; cyc(1); rd_stb_i = 1'b0; cyc(1);
    chk(rd_data_o == 16'h5A3C, "R4 update loads", int'(rd_data_o), 16'h5A3C);

    // R9 R3: continuous read at divide-by-4 starves the register
    div_sel_i = 3'd2; cyc(60);
    rd_stb_i = 1'b1; cyc(2);
    held = int'(rd_data_o);
    last_p = -1;
    for (int k = 0; k < 400; k++) begin
      status_i = 16'($urandom);
      @(negedge clk_i);
      if (int'(rd_data_o) != held) chk(1'b0, "R9 starved register", int'(rd_data_o), held);
      if (drop_pulse_o) begin
        if (last_p >= 0) chk(k - last_p == 12, "R3 R9 drop interval", k - last_p, 12);
        last_p = k;
      end
    end
    chk(int'(rd_data_o) == held, "R5 R9 value kept", int'(rd_data_o), held);

    // R7: saturation at divide-by-1 (3 cycles per slot)
    div_sel_i = 3'd0; cyc(900);
    chk(drop_run_o == 8'd255, "R7 saturate", int'(drop_run_o), 255);
    cnt = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk_i); if (drop_pulse_o) cnt++; end
    chk(cnt == 10, "R6 R3 pulse count div1", cnt, 10);

    // R7 R4: release reads, run clears and register refreshes
    status_i = 16'h1234; rd_stb_i = 1'b0; cyc(8);
    chk(drop_run_o == '0, "R7 clear", int'(drop_run_o), 0);
    rd_stb_i = 1'b1; cyc(1); rd_stb_i = 1'b0; cyc(1);
    chk(rd_data_o == 16'h1234, "R4 after starvation", int'(rd_data_o), 16'h1234);

    // R2: out-of-range code divides by 16; count pulses over 480 cycles
    div_sel_i = 3'd7; cyc(80);
    rd_stb_i = 1'b1; cnt = 0;
    for (int k = 0; k < 480; k++) begin @(negedge clk_i); if (drop_pulse_o) cnt++; end
    chk(cnt == 10, "R2 R3 pulse count div16", cnt, 10);
    rd_stb_i = 1'b0; cyc(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule